// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block collects eight interrupt request lines and decides which one the processor should service next. It keeps three 8-bit masks: requests waiting for acknowledgement (pending), levels being serviced (in service), and a software-written block mask. A priority resolver compares the best unblocked pending request with the best in-service level. It raises `int_o` only when the new request outranks everything already in service, so higher levels can nest above lower ones.

The processor answers with a one-cycle `ack_i` pulse. The block then marks the winner as in service and presents an 8-bit vector: a programmable 5-bit base with the level number in the low three bits. Software ends service through end-of-interrupt (EOI) commands on a small register write port. The same port sets the block mask, the trigger mode (edge or level), the priority scheme (fixed or rotating) and the vector base. An acknowledge that arrives with nothing to hand out yields a spurious vector for level 7.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset `int_o`=0 and `vec_o`=0x00. All three masks are empty, the base is 0, the block is in edge mode with fixed priority, and the rotation pointer makes level 7 the lowest.
- R2: Write port: address 0 writes the block mask (bit i = 1 blocks level i); address 1 writes the mode (bit 0 = 1 level-triggered, bit 1 = 1 rotating); address 2 writes the base from data[7:3]; address 3 is an EOI command (data[3] = 1 specific, level in data[2:0]; data[3] = 0 non-specific). A blocked level never makes `int_o` high, and its pending bit is kept.
- R3: In edge mode a 0-to-1 change of `req_i[i]` between two clock edges sets pending bit i after the second edge. The bit stays set when the request drops and is cleared only by the acknowledge of level i. A new edge in the same cycle as that clear keeps the bit set.
- R4: In level mode the pending mask equals `req_i` as sampled at the previous clock edge.
- R5: `int_o` is high exactly when some unblocked pending level exists and the best of them has strictly higher priority than every in-service level. It depends on registered state only.
- R6: In fixed priority mode level 0 is the highest and level 7 the lowest.
- R7: In rotating mode any EOI for level n makes level n the lowest and level n+1 (mod 8) the highest.
- R8: `ack_i` while `int_o` is high sets the in-service bit of the winning level. From the next cycle `vec_o` = {base, level}, held until the next acknowledge.
- R9: `ack_i` while `int_o` is low gives `vec_o` = {base, 3'b111} on the next cycle. It sets no in-service bit and clears no pending bit.
- R10: A non-specific EOI clears the highest-priority set in-service bit and does nothing when none is set. A specific EOI clears the named bit.
- R11: An acknowledge and an EOI in the same cycle both take effect. The winner and `int_o` come from the state before the cycle, the EOI clears its bit, and the acknowledge sets the winner's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Interrupt request lines, bit i = level i |
| ack_i | input | 1 | One-cycle interrupt acknowledge from the processor |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 mask, 1 mode, 2 base, 3 EOI |
| wr_data_i | input | 8 | Register write data |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last acknowledge |

## Verification
Two events can land in the same cycle. The first is an acknowledge together with an EOI write. The second, in edge mode, is a fresh rising edge on a level together with the acknowledge that clears that level's pending bit. Directed steps create both on purpose, with hand-worked vector and `int_o` values. Random traffic also makes them collide often, because acknowledges and command writes are drawn independently each cycle. A cycle-accurate reference model in the bench judges every cycle, and it applies the EOI before the acknowledge and lets a new edge win over the clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
    // Number of levels; must be a power of two so the rotation wraps naturally.
    localparam int NLVL = 8;
    localparam int LW   = $clog2(NLVL);
    localparam int VW   = 8;
    localparam int BW   = VW - LW;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_MODE = 2'd1,
        SEL_BASE = 2'd2,
        SEL_CMD  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NLVL-1:0] pend;
        logic [NLVL-1:0] mask;
        logic [NLVL-1:0] isr;
        logic [NLVL-1:0] req_prev;
        logic [LW-1:0]   low;
        logic [BW-1:0]   base;
        logic            lvl;
        logic            rot;
        logic [VW-1:0]   vec;
    } ctl_st_t;
endpackage

// File: rtl/irq_rank_pick.sv
// Finds the highest-priority set bit of a vector. Rank 0 is the level just
// after the lowest-priority pointer.
module irq_rank_pick #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] low,
    output logic          found,
    output logic [LW-1:0] rank,
    output logic [LW-1:0] level
);
    always_comb begin
        logic [LW-1:0] idx;
        found = 1'b0;
        rank  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            idx = low + LW'(i) + LW'(1);
            if (vec[idx]) begin
                found = 1'b1;
                rank  = LW'(i);
            end
        end
        level = rank + low + LW'(1);
    end
endmodule

// File: rtl/irq_pend_track.sv
// Next pending mask: follows the lines in level mode, latches rising edges
// in edge mode (a new edge wins over an acknowledge clear).
module irq_pend_track #(
    parameter int N = 8
) (
    input  logic         lvl_mode,
    input  logic [N-1:0] req,
    input  logic [N-1:0] req_prev,
    input  logic [N-1:0] pend_q,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_d
);
    logic [N-1:0] rise;

    always_comb begin
        rise = req & ~req_prev;
        if (lvl_mode) begin
            pend_d = req;
        end else begin
            pend_d = (pend_q & ~clr) | rise;
        end
    end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] req_i,
    input  logic            ack_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_addr_i,
    input  logic [7:0]      wr_data_i,
    output logic            int_o,
    output logic [VW-1:0]   vec_o
);
    localparam int NPICK = 2;   // 0: requests, 1: in service

    ctl_st_t st_q, st_d;

    logic [LW-1:0]   eff_low;
    logic [NLVL-1:0] p_vec   [NPICK];
    logic [NPICK-1:0] p_found;
    logic [LW-1:0]   p_rank  [NPICK];
    logic [LW-1:0]   p_level [NPICK];
    logic            int_w;
    logic [NLVL-1:0] eoi_clr;
    logic [NLVL-1:0] ack_clr;
    logic [NLVL-1:0] pend_nx;
    logic            cmd_w;

    // Fixed mode uses the top level as the permanent lowest.
    assign eff_low  = st_q.rot ? st_q.low : LW'(NLVL - 1);
    assign p_vec[0] = st_q.pend & ~st_q.mask;
    assign p_vec[1] = st_q.isr;

    generate
        for (genvar g = 0; g < NPICK; g++) begin : g_pick
            irq_rank_pick #(.N(NLVL), .LW(LW)) u_pick (
                .vec   (p_vec[g]),
                .low   (eff_low),
                .found (p_found[g]),
                .rank  (p_rank[g]),
                .level (p_level[g])
            );
        end
    endgenerate

    assign int_w = p_found[0] && (!p_found[1] || (p_rank[0] < p_rank[1]));
    assign cmd_w = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_CMD);

    irq_pend_track #(.N(NLVL)) u_pend (
        .lvl_mode (st_q.lvl),
        .req      (req_i),
        .req_prev (st_q.req_prev),
        .pend_q   (st_q.pend),
        .clr      (ack_clr),
        .pend_d   (pend_nx)
    );

    always_comb begin
        st_d    = st_q;
        eoi_clr = '0;
        ack_clr = '0;

        // End of interrupt
        if (cmd_w) begin
            if (wr_data_i[LW]) begin
                eoi_clr = NLVL'(1) << wr_data_i[LW-1:0];
                if (st_q.rot) begin
                    st_d.low = wr_data_i[LW-1:0];
                end
            end else if (p_found[1]) begin
                eoi_clr = NLVL'(1) << p_level[1];
                if (st_q.rot) begin
                    st_d.low = p_level[1];
                end
            end
        end

        // Acknowledge
        if (ack_i) begin
            if (int_w) begin
                ack_clr  = NLVL'(1) << p_level[0];
                st_d.vec = {st_q.base, p_level[0]};
            end else begin
                st_d.vec = {st_q.base, {LW{1'b1}}};
            end
        end

        st_d.isr      = (st_q.isr & ~eoi_clr) | ack_clr;
        st_d.pend     = pend_nx;
        st_d.req_prev = req_i;

        if (wr_en_i) begin
            unique case (reg_sel_e'(wr_addr_i))
                SEL_MASK: st_d.mask = wr_data_i[NLVL-1:0];
                SEL_MODE: begin
                    st_d.lvl = wr_data_i[0];
                    st_d.rot = wr_data_i[1];
                end
                SEL_BASE: st_d.base = wr_data_i[7:LW];
                SEL_CMD:  ;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.low      <= LW'(NLVL - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign int_o = int_w;
    assign vec_o = st_q.vec;

    // Flat views for the checker
    logic [NLVL-1:0] pend_w, mask_w, isr_w;
    logic            lvl_w;
    assign pend_w = st_q.pend;
    assign mask_w = st_q.mask;
    assign isr_w  = st_q.isr;
    assign lvl_w  = st_q.lvl;
endmodule

module irq_ctrl8_chk
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NLVL-1:0] req_i,
    input logic            ack_i,
    input logic            wr_en_i,
    input logic [1:0]      wr_addr_i,
    input logic [7:0]      wr_data_i,
    input logic            int_o,
    input logic [VW-1:0]   vec_o,
    input logic [NLVL-1:0] pend,
    input logic [NLVL-1:0] mask,
    input logic [NLVL-1:0] isr,
    input logic            lvl
);
    logic cmd;
    assign cmd = wr_en_i && (wr_addr_i == 2'd3);

    // R2: a blocked level alone cannot raise the interrupt
    a_r2_int_needs_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((pend & ~mask) != '0));

    // R3: edge-mode pending bits only drop through an acknowledge
    a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && !ack_i) |=> ((pend & $past(pend)) == $past(pend)));

    // R4: level-mode pending follows the lines one edge later
    a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        lvl |=> (pend == $past(req_i)));

    // R8: a granted acknowledge adds exactly one in-service level
    a_r8_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o && !cmd) |=> ($countones(isr) == $countones($past(isr)) + 1));

    // R9: a spurious acknowledge returns level 7 and leaves service untouched
    a_r9_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_o && !cmd) |=> ((vec_o[LW-1:0] == '1) && (isr == $past(isr))));

    // R10: a non-specific EOI removes one level when any is in service
    a_r10_nonspec_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd && !wr_data_i[3] && (isr != '0) && !ack_i)
        |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

bind irq_ctrl8 irq_ctrl8_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .ack_i     (ack_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .int_o     (int_o),
    .vec_o     (vec_o),
    .pend      (pend_w),
    .mask      (mask_w),
    .isr       (isr_w),
    .lvl       (lvl_w)
);

// File: tb/tb_irq_ctrl8.sv
`timescale 1ns/1ps
module tb_irq_ctrl8;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_i;
    logic       ack_i;
    logic       wr_en_i;
    logic [1:0] wr_addr_i;
    logic [7:0] wr_data_i;
    logic       int_o;
    logic [7:0] vec_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_ctrl8 dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .int_o(int_o), .vec_o(vec_o)
    );

    // Reference model state
    logic [7:0] m_pend, m_mask, m_isr, m_reqp, m_vec;
    logic [2:0] m_low;
    logic [4:0] m_base;
    logic       m_lvl, m_rot;

    function automatic int rank_of(input logic [7:0] v, input logic [2:0] lo);
        for (int r = 0; r < 8; r++) begin
            if (v[(int'(lo) + 1 + r) % 8]) return r;
        end
        return 8;
    endfunction

    function automatic logic [2:0] lvl_of(input int r, input logic [2:0] lo);
        return 3'((int'(lo) + 1 + r) % 8);
    endfunction

    function automatic logic [2:0] eff_low();
        return m_rot ? m_low : 3'd7;
    endfunction

    function automatic logic m_int();
        int cr, ir;
        cr = rank_of(m_pend & ~m_mask, eff_low());
        ir = rank_of(m_isr, eff_low());
        return (cr < 8) && (cr < ir);
    endfunction

    task automatic model_reset();
        m_pend = '0; m_mask = '0; m_isr = '0; m_reqp = '0; m_vec = '0;
        m_low = 3'd7; m_base = '0; m_lvl = 1'b0; m_rot = 1'b0;
    endtask

    task automatic model_step(input logic [7:0] rq, input logic ak, input logic we,
                              input logic [1:0] wa, input logic [7:0] wd);
        logic [7:0] n_isr, clr, eclr;
        logic [2:0] n_low, lo, wl;
        int cr, ir;
        logic gi;
        lo = eff_low();
        cr = rank_of(m_pend & ~m_mask, lo);
        ir = rank_of(m_isr, lo);
        gi = m_int();
        n_low = m_low; clr = '0; eclr = '0;
        if (we && wa == 2'd3) begin
            if (wd[3]) begin
                eclr = 8'd1 << wd[2:0];
                if (m_rot) n_low = wd[2:0];
            end else if (ir < 8) begin
                eclr = 8'd1 << lvl_of(ir, lo);
                if (m_rot) n_low = lvl_of(ir, lo);
            end
        end
        n_isr = m_isr & ~eclr;
        if (ak) begin
            if (gi) begin
                wl = lvl_of(cr, lo);
                clr = 8'd1 << wl;
                n_isr = n_isr | clr;
                m_vec = {m_base, wl};
            end else begin
                m_vec = {m_base, 3'b111};
            end
        end
        if (m_lvl) m_pend = rq;
        else       m_pend = (m_pend & ~clr) | (rq & ~m_reqp);
        m_reqp = rq;
        m_isr = n_isr;
        m_low = n_low;
        if (we) begin
            case (wa)
                2'd0: m_mask = wd;
                2'd1: begin m_lvl = wd[0]; m_rot = wd[1]; end
                2'd2: m_base = wd[7:3];
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle from a negedge, then compare at the next negedge.
    task automatic drive(input logic [7:0] rq, input logic ak, input logic we,
                         input logic [1:0] wa, input logic [7:0] wd);
        req_i = rq; ack_i = ak; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
        model_step(rq, ak, we, wa, wd);
        @(negedge clk);
        chk("R5 model int_o", {7'd0, int_o}, {7'd0, m_int()});
        chk("R8 model vec_o", vec_o, m_vec);
    endtask

    task automatic idle(input logic [7:0] rq);
        drive(rq, 1'b0, 1'b0, 2'd0, 8'd0);
    endtask
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        drive(8'd0, 1'b0, 1'b1, a, d);
    endtask
    task automatic ack(input logic [7:0] rq);
        drive(rq, 1'b1, 1'b0, 2'd0, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        rst_n = 1'b0; req_i = '0; ack_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset int_o", {7'd0, int_o}, 8'd0);
        chk("R1 reset vec_o", vec_o, 8'h00);

        // Fixed priority, edge mode, base 0x40
        wr(2'd2, 8'h40);
        idle(8'h08); idle(8'h00);
        chk("R3 pending held after request drops", {7'd0, int_o}, 8'd1);
        ack(8'h00);
        chk("R8 vector level 3", vec_o, 8'h43);
        chk("R8 in service blocks same level", {7'd0, int_o}, 8'd0);
        idle(8'h20); idle(8'h00);
        chk("R5 lower level waits behind service", {7'd0, int_o}, 8'd0);
        idle(8'h02); idle(8'h00);
        chk("R6 level 1 outranks level 3", {7'd0, int_o}, 8'd1);
        ack(8'h00);
        chk("R8 vector level 1", vec_o, 8'h41);
        wr(2'd3, 8'h00);
        chk("R10 non-specific clears level 1 only", {7'd0, int_o}, 8'd0);
        wr(2'd3, 8'h00);
        chk("R10 second non-specific clears level 3", {7'd0, int_o}, 8'd1);
        wr(2'd0, 8'h20);
        chk("R2 blocked level drops int", {7'd0, int_o}, 8'd0);
        ack(8'h00);
        chk("R9 spurious vector", vec_o, 8'h47);
        wr(2'd0, 8'h00);
        chk("R9 pending kept after spurious ack", {7'd0, int_o}, 8'd1);
        ack(8'h00);
        chk("R8 vector level 5", vec_o, 8'h45);

        // Rotating mode
        wr(2'd1, 8'h02);
        wr(2'd3, 8'h0D);                 // specific EOI level 5
        chk("R10 specific EOI empties service", {7'd0, int_o}, 8'd0);
        idle(8'h81); idle(8'h00);
        chk("R7 request present", {7'd0, int_o}, 8'd1);
        ack(8'h00);
        chk("R7 level 7 wins after EOI of 5", vec_o, 8'h47);
        chk("R7 level 0 below level 7", {7'd0, int_o}, 8'd0);
        idle(8'h40); idle(8'h00);
        chk("R7 level 6 highest", {7'd0, int_o}, 8'd1);
        drive(8'h00, 1'b1, 1'b1, 2'd3, 8'h00);   // ack + non-specific EOI
        chk("R11 ack with EOI vector", vec_o, 8'h46);
        chk("R11 level 0 outranks 6 after rotate", {7'd0, int_o}, 8'd1);

        // Level mode, fixed priority
        wr(2'd1, 8'h01);
        idle(8'h10);
        chk("R4 level request seen", {7'd0, int_o}, 8'd1);
        idle(8'h00);
        chk("R4 level request gone", {7'd0, int_o}, 8'd0);
        ack(8'h00);
        chk("R9 spurious after line drop", vec_o, 8'h47);

        // Edge mode: new edge together with acknowledge clear
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h0E);
        idle(8'h04); idle(8'h00);
        ack(8'h04);
        chk("R3 vector level 2", vec_o, 8'h42);
        wr(2'd3, 8'h0A);
        chk("R3 new edge survives ack clear", {7'd0, int_o}, 8'd1);

        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] rq, wd;
            logic ak, we;
            logic [1:0] wa;
            rq = 8'($urandom & $urandom);
            ak = ($urandom % 5) == 0;
            we = ($urandom % 7) == 0;
            wa = 2'($urandom % 4);
            if (wa == 2'd0)      wd = 8'($urandom & $urandom & $urandom);
            else if (wa == 2'd3) wd = 8'($urandom % 16);
            else                 wd = 8'($urandom);
            drive(rq, ak, we, wa, wd);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule